// File: doc/BRIEF.md
# Clock-Generator Control Register Slave

This block is the serial control port of a clock generator. It is a two-wire (I2C) slave that works on SCL and SDA after they have been synchronized into a fast system clock. It drives SDA only by pulling it low, through an open-drain enable. It holds the control bytes that pick the output frequency, turn spread spectrum on and set its depth, enable or stop each output group, and tristate every output. These bytes drive parallel outputs, and the synthesizer and output buffers use those outputs directly.

A write has a fixed layout. The address byte comes first. Two more bytes follow, a command byte and a count byte. The slave acknowledges both and ignores their values. Every later byte goes to the next register, starting at index 0. A read needs no command byte: after the read address, the slave streams bytes from index 0 upward for as long as the master acknowledges them. Index 4 returns the strap bits captured at reset. Indices 11 and 12 return fixed identification bytes.

The controller is a state machine with these states. **IDLE** waits for a START. **ADDR** shifts in the address byte. **SKIP** takes the command byte and the count byte. **WRITE** takes data bytes. **ACK** pulls SDA low for one SCL period. **READ** shifts a byte out. **MACK** samples the master's acknowledge. The transitions are as follows:
- START moves any state to ADDR, and STOP moves any state to IDLE.
- A matching write address goes ADDR→ACK→SKIP, and the second skipped byte goes SKIP→ACK→WRITE.
- Each data byte goes WRITE→ACK→WRITE.
- A matching read address goes ADDR→ACK→READ, and each byte sent goes READ→MACK.
- From MACK, a master ACK goes to READ and a master NACK goes to IDLE.
- An address that does not match goes ADDR→IDLE.

Top module: `clkctl_i2c_regs`

## Requirements
- R1: After reset, the control bytes are index0=0x00, index1=0xCF, index2=0xFF, index3=0xFF and index5=0x93. They appear on the outputs and in read-back.
- R2: The device address is 7'h69, so the write byte is 0xD2 and the read byte is 0xD3. The slave acknowledges either byte by holding SDA low through the ninth SCL high phase.
- R3: The slave does not acknowledge any other address byte. It then keeps SDA released and ignores every later byte until the next START.
- R4: In a write, the slave acknowledges the two bytes after the address and discards their values. It writes the following data bytes to index 0, 1, 2 and so on, acknowledging each one.
- R5: In a read, the slave returns bytes from index 0 upward, MSB first. It moves to the next index after each master ACK, and it releases SDA after a master NACK.
- R6: Index 4 reads as {1, strap[3:0], 3'b111}, using the strap bits sampled while reset is low. Changes on the strap input after reset have no effect.
- R7: Index 11 reads 0x62 and index 12 reads 0x51. Indices 6 to 10 and indices above 12 read 0x00. The slave acknowledges writes to indices 4 and 6 to 12 but discards them.
- R8: A START (SDA falls while SCL is high) or a STOP (SDA rises while SCL is high) abandons a partly received byte without writing it. The next transfer starts again at index 0.
- R9: The outputs decode the control bytes as follows. freq_sel = index0[7:2]. sw_sel = index0[1]. tristate = index0[0]. ss_en = index1[5]. ss_wide = index1[4], where 0 means ±0.25% and 1 means ±0.5%. The raw bytes of index 1, 2, 3 and 5 are also brought out.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: A written byte reaches the outputs on the SCL falling edge that ends its eighth bit. It does not appear earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the strap bits are sampled while it is low |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (resolved bus level) |
| strap_fs_i | input | 4 | Hardware frequency straps |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| freq_sel_o | output | 6 | Software frequency selection code |
| sw_sel_o | output | 1 | 1 = use software selection |
| tristate_o | output | 1 | 1 = tristate all clock outputs |
| ss_en_o | output | 1 | Spread spectrum enable |
| ss_wide_o | output | 1 | Spread depth, 0 = ±0.25%, 1 = ±0.5% |
| cpu_ctl_o | output | 8 | Control byte at index 1 |
| pci_en_o | output | 8 | Control byte at index 2 |
| misc_en_o | output | 8 | Control byte at index 3 |
| aux_o | output | 8 | Control byte at index 5 |

## Verification
Two things happen on the same system clock. The SCL falling edge that ends a data byte commits that byte to the register bank, and the same edge starts the acknowledge drive. The bench checks this by holding SCL high after the eighth bit: the output must still show the old value there, and must show the new value once SCL falls, while SDA is held low for the acknowledge. A START or STOP that arrives with a byte partly shifted in competes with the commit. The bench sends four bits followed by a repeated START, and three bits followed by a STOP. It then judges both cases by reading back that index 0 was rewritten only by the new transfer and that index 1 did not change.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_SKIP,
        ST_WRITE,
        ST_READ,
        ST_MACK
    } i2c_st_e;

    localparam int          STRAP_IDX = 4;
    localparam int          ID_IDX_A  = 11;
    localparam int          ID_IDX_B  = 12;
    localparam logic [7:0]  ID_BYTE_A = 8'h62;
    localparam logic [7:0]  ID_BYTE_B = 8'h51;

    function automatic logic [7:0] reg_reset_val(input int idx);
        case (idx)
            1:       return 8'hCF;
            2, 3:    return 8'hFF;
            5:       return 8'h93;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit reg_is_rw(input int idx);
        return (idx >= 0 && idx <= 3) || idx == 5;
    endfunction

endpackage

// File: rtl/clkctl_bus_edge.sv
module clkctl_bus_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       strap_i,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [7:0]       ctl0_o,
    output logic [7:0]       ctl1_o,
    output logic [7:0]       ctl2_o,
    output logic [7:0]       ctl3_o,
    output logic [7:0]       ctl5_o
);
    import clkctl_pkg::*;

    localparam int NUM_LO = 8;
    localparam int IDX_W  = $clog2(NUM_LO);

    logic [7:0] bank_q [NUM_LO];
    logic [3:0] strap_q;

    // straps follow the pins only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_i;
    end

    for (genvar g = 0; g < NUM_LO; g++) begin : g_slot
        if (reg_is_rw(g)) begin : g_rw
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bank_q[g] <= reg_reset_val(g);
                else if (wr_en && wr_idx == PTR_W'(g))
                    bank_q[g] <= wr_data;
            end
        end else if (g == STRAP_IDX) begin : g_strap
            assign bank_q[g] = {1'b1, strap_q, 3'b111};
        end else begin : g_empty
            assign bank_q[g] = 8'h00;
        end
    end

    always_comb begin
        if (rd_idx < PTR_W'(NUM_LO))
            rd_data = bank_q[rd_idx[IDX_W-1:0]];
        else if (rd_idx == PTR_W'(ID_IDX_A))
            rd_data = ID_BYTE_A;
        else if (rd_idx == PTR_W'(ID_IDX_B))
            rd_data = ID_BYTE_B;
        else
            rd_data = 8'h00;
    end

    assign ctl0_o = bank_q[0];
    assign ctl1_o = bank_q[1];
    assign ctl2_o = bank_q[2];
    assign ctl3_o = bank_q[3];
    assign ctl5_o = bank_q[5];
endmodule

// File: rtl/clkctl_i2c_regs.sv
module clkctl_i2c_regs #(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         PTR_W    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [3:0] strap_fs_i,
    output logic       sda_oe_o,
    output logic [5:0] freq_sel_o,
    output logic       sw_sel_o,
    output logic       tristate_o,
    output logic       ss_en_o,
    output logic       ss_wide_o,
    output logic [7:0] cpu_ctl_o,
    output logic [7:0] pci_en_o,
    output logic [7:0] misc_en_o,
    output logic [7:0] aux_o
);
    import clkctl_pkg::*;

    logic scl_rise, scl_fall, start_det, stop_det;
    i2c_st_e          state_q, ret_q;
    logic [3:0]       bitcnt_q;
    logic [7:0]       shreg_q, tx_q;
    logic [PTR_W-1:0] ptr_q;
    logic             skip_seen_q, nack_q;
    logic             wr_en;
    logic [7:0]       rd_data, ctl0;

    clkctl_bus_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkctl_regbank #(.PTR_W(PTR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_fs_i),
        .wr_en   (wr_en),
        .wr_idx  (ptr_q),
        .wr_data (shreg_q),
        .rd_idx  (ptr_q),
        .rd_data (rd_data),
        .ctl0_o  (ctl0),
        .ctl1_o  (cpu_ctl_o),
        .ctl2_o  (pci_en_o),
        .ctl3_o  (misc_en_o),
        .ctl5_o  (aux_o)
    );

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ret_q       <= ST_IDLE;
            bitcnt_q    <= '0;
            shreg_q     <= '0;
            tx_q        <= '0;
            ptr_q       <= '0;
            skip_seen_q <= 1'b0;
            nack_q      <= 1'b0;
        end else if (start_det) begin
            state_q     <= ST_ADDR;
            bitcnt_q    <= '0;
            ptr_q       <= '0;
            skip_seen_q <= 1'b0;
        end else if (stop_det) begin
            state_q     <= ST_IDLE;
            ptr_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR, ST_SKIP, ST_WRITE: begin
                    if (scl_rise && bitcnt_q < 4'd8) begin
                        shreg_q  <= {shreg_q[6:0], sda_i};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (scl_fall && bitcnt_q == 4'd8) begin
                        bitcnt_q <= '0;
                        if (state_q == ST_ADDR) begin
                            if (shreg_q[7:1] == DEV_ADDR) begin
                                state_q <= ST_ACK;
                                ret_q   <= shreg_q[0] ? ST_READ : ST_SKIP;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else if (state_q == ST_SKIP) begin
                            state_q     <= ST_ACK;
                            ret_q       <= skip_seen_q ? ST_WRITE : ST_SKIP;
                            skip_seen_q <= 1'b1;
                        end else begin
                            state_q <= ST_ACK;
                            ret_q   <= ST_WRITE;
                            ptr_q   <= ptr_q + PTR_W'(1);
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state_q  <= ret_q;
                        bitcnt_q <= '0;
                        if (ret_q == ST_READ) tx_q <= rd_data;
                    end
                end
                ST_READ: begin
                    if (scl_fall) begin
                        if (bitcnt_q == 4'd7) begin
                            state_q  <= ST_MACK;
                            bitcnt_q <= '0;
                            ptr_q    <= ptr_q + PTR_W'(1);
                        end else begin
                            tx_q     <= {tx_q[6:0], 1'b0};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        nack_q <= sda_i;
                    end else if (scl_fall) begin
                        if (nack_q) begin
                            state_q <= ST_IDLE;
                        end else begin
                            state_q  <= ST_READ;
                            tx_q     <= rd_data;
                            bitcnt_q <= '0;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs of the controller
    always_comb begin
        sda_oe_o = 1'b0;
        unique case (state_q)
            ST_ACK:  sda_oe_o = 1'b1;
            ST_READ: sda_oe_o = ~tx_q[7];
            default: sda_oe_o = 1'b0;
        endcase
        wr_en = (state_q == ST_WRITE) && scl_fall && (bitcnt_q == 4'd8)
                && !start_det && !stop_det;
    end

    assign freq_sel_o = ctl0[7:2];
    assign sw_sel_o   = ctl0[1];
    assign tristate_o = ctl0[0];
    assign ss_en_o    = cpu_ctl_o[5];
    assign ss_wide_o  = cpu_ctl_o[4];
endmodule

// File: rtl/clkctl_i2c_regs_chk.sv
module clkctl_i2c_regs_chk #(
    parameter int PTR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_i,
    input logic                 sda_i,
    input logic                 sda_oe_o,
    input clkctl_pkg::i2c_st_e  state,
    input logic [PTR_W-1:0]     ptr,
    input logic [39:0]          ctl_bus
);
    logic scl_seen, sda_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_seen <= 1'b1;
            sda_seen <= 1'b1;
        end else begin
            scl_seen <= scl_i;
            sda_seen <= sda_i;
        end
    end

    p_sda_hold_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_seen && scl_i) |-> $stable(sda_oe_o));

    p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == clkctl_pkg::ST_IDLE) |-> !sda_oe_o);

    p_start_ptr_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_seen && scl_i && sda_seen && !sda_i) |=> (ptr == '0));

    p_commit_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_bus) |-> $past(scl_seen && !scl_i));
endmodule

bind clkctl_i2c_regs clkctl_i2c_regs_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_oe_o (sda_oe_o),
    .state    (state_q),
    .ptr      (ptr_q),
    .ctl_bus  ({freq_sel_o, sw_sel_o, tristate_o, cpu_ctl_o, pci_en_o, misc_en_o, aux_o})
);

// File: tb/clkctl_i2c_regs_tb.sv
`timescale 1ns/1ps
module clkctl_i2c_regs_tb;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [3:0] strap = 4'b1010;
    logic sda_oe;
    logic [5:0] freq_sel;
    logic sw_sel, tristate, ss_en, ss_wide;
    logic [7:0] cpu_ctl, pci_en, misc_en, aux;
    logic sda_line;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] model [16];
    logic [7:0] wbuf [16];

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    clkctl_i2c_regs u_dut (
        .clk (clk), .rst_n (rst_n), .scl_i (scl), .sda_i (sda_line),
        .strap_fs_i (strap), .sda_oe_o (sda_oe), .freq_sel_o (freq_sel),
        .sw_sel_o (sw_sel), .tristate_o (tristate), .ss_en_o (ss_en),
        .ss_wide_o (ss_wide), .cpu_ctl_o (cpu_ctl), .pci_en_o (pci_en),
        .misc_en_o (misc_en), .aux_o (aux)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input int idx);
        if (idx == 4)  return 8'hD7;         // R6: {1, 4'b1010, 3'b111}
        if (idx == 11) return 8'h62;
        if (idx == 12) return 8'h51;
        if (idx <= 3 || idx == 5) return model[idx];
        return 8'h00;
    endfunction

    task automatic i2c_start;
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic get_ack(output logic ack);
        logic oe_a;
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(1);
        ack = !sda_line; oe_a = sda_oe;
        tick(Q - 1);
        check8("R10 ack drive steady while SCL high", {7'd0, sda_oe}, {7'd0, oe_a});
        scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a;
        send_bits(b);
        get_ack(a);
        check8(tag, {7'd0, a}, {7'd0, exp_ack});
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] b);
        logic oe_a;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q); scl = 1'b1; tick(1);
            b[i] = sda_line; oe_a = sda_oe;
            tick(Q - 1);
            check8("R10 data drive steady while SCL high", {7'd0, sda_oe}, {7'd0, oe_a});
            scl = 1'b0; tick(Q);
        end
        sda_m = last; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic check_outputs(input string tag);
        check8({tag, " R9 freq_sel"}, {2'd0, freq_sel}, {2'd0, model[0][7:2]});
        check8({tag, " R9 sw/tristate"}, {6'd0, sw_sel, tristate}, {6'd0, model[0][1:0]});
        check8({tag, " R9 spread bits"}, {6'd0, ss_en, ss_wide}, {6'd0, model[1][5:4]});
        check8({tag, " R9 idx1"}, cpu_ctl, model[1]);
        check8({tag, " R9 idx2"}, pci_en, model[2]);
        check8({tag, " R9 idx3"}, misc_en, model[3]);
        check8({tag, " R9 idx5"}, aux, model[5]);
    endtask

    // R4/R7: write n bytes from wbuf starting at index 0
    task automatic write_frame(input int n);
        i2c_start;
        send_byte(8'hD2, 1'b1, "R2 write address ack");
        send_byte(8'hA5, 1'b1, "R4 command byte ack");
        send_byte(8'h3C, 1'b1, "R4 count byte ack");
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], 1'b1, (i == 4 || i > 5) ? "R7 ro index ack" : "R4 data ack");
            if (i <= 3 || i == 5) model[i] = wbuf[i];
        end
        i2c_stop;
    endtask

    // R5: read n bytes from index 0, NACK on last
    task automatic read_frame(input int n, input string tag);
        logic [7:0] b;
        i2c_start;
        send_byte(8'hD3, 1'b1, "R2 read address ack");
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            check8($sformatf("%s R5 idx%0d", tag, i), b, model_rd(i));
        end
        check8("R5 released after NACK", {7'd0, sda_oe}, 8'd0);
        i2c_stop;
    endtask

    task automatic t_reset;
        check8("R1 no drive at reset", {7'd0, sda_oe}, 8'd0);
        check_outputs("R1 defaults");
        read_frame(13, "R1/R6/R7 readback");
    endtask

    task automatic t_strap_change;
        strap = 4'b0101;
        tick(20);
        read_frame(5, "R6 strap held");
    endtask

    task automatic t_write_seq;
        logic a;
        i2c_start;
        send_byte(8'hD2, 1'b1, "R2 write address ack");
        send_byte(8'h00, 1'b1, "R4 command byte ack");
        send_byte(8'hFF, 1'b1, "R4 count byte ack");
        for (int i = 7; i >= 1; i--) send_bit(wbuf[0][i]);
        sda_m = wbuf[0][0]; tick(Q); scl = 1'b1; tick(Q);
        check8("R11 no commit before eighth fall", {2'd0, freq_sel}, {2'd0, model[0][7:2]});
        scl = 1'b0; tick(Q);
        check8("R11 commit at eighth fall", {2'd0, freq_sel}, {2'd0, wbuf[0][7:2]});
        get_ack(a);
        check8("R4 first data ack", {7'd0, a}, 8'd1);
        model[0] = wbuf[0];
        for (int i = 1; i < 6; i++) begin
            send_byte(wbuf[i], 1'b1, "R4 data ack");
            if (i != 4) model[i] = wbuf[i];
        end
        i2c_stop;
        check_outputs("R4 sequential write");
        read_frame(6, "R4 readback");
    endtask

    task automatic t_wrong_addr;
        i2c_start;
        send_byte(8'hA4, 1'b0, "R3 foreign address nack");
        send_byte(8'h00, 1'b0, "R3 ignored byte");
        send_byte(8'hD2, 1'b0, "R3 own address without START");
        send_byte(8'h11, 1'b0, "R3 ignored data");
        i2c_stop;
        check_outputs("R3 unchanged");
    endtask

    task automatic t_ro_writes;
        for (int i = 0; i < 13; i++) wbuf[i] = 8'(8'h30 + i);
        write_frame(13);
        read_frame(13, "R7 after ro writes");
        check_outputs("R7 outputs");
    endtask

    task automatic t_abort;
        i2c_start;
        send_byte(8'hD2, 1'b1, "R2 write address ack");
        send_byte(8'h01, 1'b1, "R4 command byte ack");
        send_byte(8'h02, 1'b1, "R4 count byte ack");
        send_byte(8'h12, 1'b1, "R4 data ack");
        model[0] = 8'h12;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        i2c_start;
        send_byte(8'hD2, 1'b1, "R8 address after repeated START");
        send_byte(8'h00, 1'b1, "R8 command");
        send_byte(8'h00, 1'b1, "R8 count");
        send_byte(8'h77, 1'b1, "R8 data");
        model[0] = 8'h77;
        i2c_stop;
        check_outputs("R8 repeated START");
        i2c_start;
        send_byte(8'hD2, 1'b1, "R2 write address ack");
        send_byte(8'h00, 1'b1, "R4 command byte ack");
        send_byte(8'h00, 1'b1, "R4 count byte ack");
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        i2c_stop;
        check_outputs("R8 STOP mid-byte");
        read_frame(2, "R8 readback");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        model[1] = 8'hCF; model[2] = 8'hFF; model[3] = 8'hFF; model[5] = 8'h93;
        wbuf[0] = 8'hAE; wbuf[1] = 8'h35; wbuf[2] = 8'h5A;
        wbuf[3] = 8'h0F; wbuf[4] = 8'h00; wbuf[5] = 8'h6C;
        tick(10);
        rst_n = 1'b1;
        tick(10);
        t_reset;
        t_strap_change;
        t_write_seq;
        t_wrong_addr;
        t_ro_writes;
        t_abort;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule